// File: doc/BRIEF.md
# Banked Register-File Address Unit

This unit turns operand references from a small 8-bit controller into physical data-memory addresses. The memory is split into a low common region, which every bank shares, and an upper window that is repeated once per bank. A reference comes from one of three sources: the direct operand byte, or one of two indirect pointers that the unit holds. The unit resolves a bank and an offset for a read port and a write port in the same cycle. This allows a one-cycle copy between the locations of the two pointers, even when those locations sit in different banks.

The direct path takes its bank from the upper nibble of the bank-select register. Each indirect pointer holds an offset byte, a bank byte of its own and a 2-bit step field. A two-state mode machine chooses how the pointers behave. In MODE_COMPAT, indirect accesses take the bank-select nibble as their bank and the offset counts modulo 256. In MODE_EXTENDED, each pointer supplies its own bank, and stepping crosses from the end of one bank's window into the next bank. The machine takes the ENTER_EXT transition when the mode command is written with 1 and the LEAVE_EXT transition when it is written with 0; any other cycle holds the state.

Top module: `bank_addr_unit`

## Requirements
- R1: When a resolved offset is below 0x20 (the common region), its bank output is 0 on both ports, whatever the source and whatever bank bits apply.
- R2: The source selects use this encoding: 00 is direct, 01 is pointer 0, 10 is pointer 1, and 11 is also direct. A direct reference outputs the operand byte as the offset and the upper nibble of the bank-select register as the bank.
- R3: In MODE_EXTENDED, an indirect reference outputs the pointer's offset byte and its own bank byte.
- R4: In MODE_COMPAT, an indirect reference outputs the pointer's offset byte with the bank-select nibble as its bank.
- R5: Writing the bank-select register never changes either pointer's offset or bank.
- R6: In MODE_EXTENDED, a pointer that increments from offset 0xFF moves to offset 0x20 and its bank byte goes up by one.
- R7: In MODE_EXTENDED, a pointer that decrements from offset 0x20 moves to offset 0xFF and its bank byte goes down by one.
- R8: The step field uses this encoding: 00 and 11 hold, 01 increments, 10 decrements. A pointer steps only on the clock edge that ends an enabled access using it. The address output during that access is the value before the step.
- R9: A single enabled access can read through pointer 0 and write through pointer 1 in different banks. Both addresses resolve in that cycle, and both pointers step on the following edge.
- R10: After reset, the bank-select register and both pointers are zero, and the mode is MODE_COMPAT.
- R11: In MODE_COMPAT, a pointer step wraps the offset modulo 256 and leaves the pointer's bank byte unchanged.
- R12: A pointer load on the same edge as a step of that pointer wins: the loaded values are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access enable; when high, the pointers in use step |
| rd_sel | input | 2 | Read source select |
| rd_dir_addr | input | 8 | Direct operand byte for the read port |
| wr_sel | input | 2 | Write source select |
| wr_dir_addr | input | 8 | Direct operand byte for the write port |
| bsr_we | input | 1 | Bank-select register write enable |
| bsr_wdata | input | 8 | Bank-select value; the bank is in bits 7:4 |
| mode_we | input | 1 | Mode command write enable |
| mode_ext | input | 1 | Mode command value: 1 extended, 0 compatible |
| ptr_ld | input | 2 | Per-pointer load strobe |
| ptr_ld_off | input | 8 | Offset value to load |
| ptr_ld_bank | input | BANK_W | Bank byte to load |
| ptr_ld_step | input | 2 | Step field to load |
| rd_bank | output | BANK_W | Resolved read bank |
| rd_off | output | 8 | Resolved read offset |
| wr_bank | output | BANK_W | Resolved write bank |
| wr_off | output | 8 | Resolved write offset |

## Verification
The bench builds the unit with its defaults: an 8-bit pointer bank byte and a window starting at offset 32. With these values, both window edges can be reached from a single loaded pointer: the 0xFF-to-0x20 crossing and the 0x20-to-0xFF crossing each show up after one or two steps. Bank numbers above 15 stay distinct from the 4-bit bank-select nibble, so a test can tell which bank source an address used. A behavioural RAM indexed by bank and offset confirms that the cross-bank copy moves its byte to the right place in one access.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'b00,
        SRC_PTR0   = 2'b01,
        SRC_PTR1   = 2'b10,
        SRC_DIRALT = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        STEP_HOLD    = 2'b00,
        STEP_INC     = 2'b01,
        STEP_DEC     = 2'b10,
        STEP_HOLDALT = 2'b11
    } step_e;

    typedef enum logic {
        MODE_COMPAT   = 1'b0,
        MODE_EXTENDED = 1'b1
    } mode_e;

endpackage

// File: rtl/bank_ptr.sv
module bank_ptr
    import bank_addr_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext,
    input  logic              use_en,
    input  logic              ld,
    input  logic [7:0]        ld_off,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [1:0]        ld_step,
    output logic [7:0]        off_q,
    output logic [BANK_W-1:0] bank_q
);
    localparam logic [7:0]        WIN_LO   = 8'(WIN_BASE);
    localparam logic [7:0]        WIN_HI   = 8'hFF;
    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    step_e             step_q;
    logic [7:0]        off_d;
    logic [BANK_W-1:0] bank_d;

    always_comb begin
        off_d  = off_q;
        bank_d = bank_q;
        unique case (step_q)
            STEP_INC: begin
                if (ext && off_q == WIN_HI) begin
                    off_d  = WIN_LO;
                    bank_d = bank_q + BANK_ONE;
                end else begin
                    off_d = off_q + 8'd1;
                end
            end
            STEP_DEC: begin
                if (ext && off_q == WIN_LO) begin
                    off_d  = WIN_HI;
                    bank_d = bank_q - BANK_ONE;
                end else begin
                    off_d = off_q - 8'd1;
                end
            end
            STEP_HOLD, STEP_HOLDALT: begin
                off_d  = off_q;
                bank_d = bank_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            bank_q <= '0;
            step_q <= STEP_HOLD;
        end else if (ld) begin
            off_q  <= ld_off;
            bank_q <= ld_bank;
            step_q <= step_e'(ld_step);
        end else if (use_en) begin
            off_q  <= off_d;
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/bank_resolve.sv
module bank_resolve
    import bank_addr_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_BASE = 32
) (
    input  logic [1:0]        sel,
    input  logic [7:0]        dir_addr,
    input  logic [BANK_W-1:0] dir_bank,
    input  logic              ext,
    input  logic [7:0]        p0_off,
    input  logic [BANK_W-1:0] p0_bank,
    input  logic [7:0]        p1_off,
    input  logic [BANK_W-1:0] p1_bank,
    output logic [BANK_W-1:0] bank,
    output logic [7:0]        off
);
    localparam logic [7:0] WIN_LO = 8'(WIN_BASE);

    logic [BANK_W-1:0] raw_bank;

    always_comb begin
        unique case (src_e'(sel))
            SRC_PTR0: begin
                off      = p0_off;
                raw_bank = ext ? p0_bank : dir_bank;
            end
            SRC_PTR1: begin
                off      = p1_off;
                raw_bank = ext ? p1_bank : dir_bank;
            end
            SRC_DIRECT, SRC_DIRALT: begin
                off      = dir_addr;
                raw_bank = dir_bank;
            end
        endcase
        bank = (off < WIN_LO) ? '0 : raw_bank;
    end
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
    import bank_addr_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [1:0]        rd_sel,
    input  logic [7:0]        rd_dir_addr,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_dir_addr,
    input  logic              bsr_we,
    input  logic [7:0]        bsr_wdata,
    input  logic              mode_we,
    input  logic              mode_ext,
    input  logic [1:0]        ptr_ld,
    input  logic [7:0]        ptr_ld_off,
    input  logic [BANK_W-1:0] ptr_ld_bank,
    input  logic [1:0]        ptr_ld_step,
    output logic [BANK_W-1:0] rd_bank,
    output logic [7:0]        rd_off,
    output logic [BANK_W-1:0] wr_bank,
    output logic [7:0]        wr_off
);
    localparam int NPTR = 2;

    mode_e             mode_q, mode_d;
    logic              ext_on;
    logic [7:0]        bsr_q;
    logic [BANK_W-1:0] dir_bank;
    logic [NPTR-1:0]   ptr_use;
    logic [7:0]        ptr_off  [NPTR];
    logic [BANK_W-1:0] ptr_bank [NPTR];

    // Mode machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_COMPAT;
        else        mode_q <= mode_d;
    end

    // Mode machine: ENTER_EXT / LEAVE_EXT transitions and output
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_COMPAT:   if (mode_we && mode_ext)  mode_d = MODE_EXTENDED;
            MODE_EXTENDED: if (mode_we && !mode_ext) mode_d = MODE_COMPAT;
        endcase
        ext_on = (mode_q == MODE_EXTENDED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bsr_q <= '0;
        else if (bsr_we) bsr_q <= bsr_wdata;
    end

    assign dir_bank = BANK_W'(bsr_q[7:4]);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam logic [1:0] MY_SEL = 2'(g + 1);
        assign ptr_use[g] = acc_en && (rd_sel == MY_SEL || wr_sel == MY_SEL);

        bank_ptr #(.BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ext     (ext_on),
            .use_en  (ptr_use[g]),
            .ld      (ptr_ld[g]),
            .ld_off  (ptr_ld_off),
            .ld_bank (ptr_ld_bank),
            .ld_step (ptr_ld_step),
            .off_q   (ptr_off[g]),
            .bank_q  (ptr_bank[g])
        );
    end

    bank_resolve #(.BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_rd (
        .sel      (rd_sel),
        .dir_addr (rd_dir_addr),
        .dir_bank (dir_bank),
        .ext      (ext_on),
        .p0_off   (ptr_off[0]),
        .p0_bank  (ptr_bank[0]),
        .p1_off   (ptr_off[1]),
        .p1_bank  (ptr_bank[1]),
        .bank     (rd_bank),
        .off      (rd_off)
    );

    bank_resolve #(.BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_wr (
        .sel      (wr_sel),
        .dir_addr (wr_dir_addr),
        .dir_bank (dir_bank),
        .ext      (ext_on),
        .p0_off   (ptr_off[0]),
        .p0_bank  (ptr_bank[0]),
        .p1_off   (ptr_off[1]),
        .p1_bank  (ptr_bank[1]),
        .bank     (wr_bank),
        .off      (wr_off)
    );
endmodule

// File: rtl/bank_addr_checker.sv
module bank_addr_checker #(
    parameter int BANK_W   = 8,
    parameter int WIN_BASE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext,
    input logic              acc_en,
    input logic [1:0]        rd_sel,
    input logic [1:0]        wr_sel,
    input logic              bsr_we,
    input logic [1:0]        ptr_ld,
    input logic [1:0]        ld_step,
    input logic [7:0]        p0_off,
    input logic [BANK_W-1:0] p0_bank,
    input logic [BANK_W-1:0] rd_bank,
    input logic [7:0]        rd_off,
    input logic [BANK_W-1:0] wr_bank,
    input logic [7:0]        wr_off
);
    localparam logic [7:0]        WIN_LO   = 8'(WIN_BASE);
    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    logic [1:0] step0;
    logic       use0;

    // Track pointer 0's step field from its load port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         step0 <= 2'b00;
        else if (ptr_ld[0]) step0 <= ld_step;
    end

    assign use0 = acc_en && (rd_sel == 2'b01 || wr_sel == 2'b01);

    AST_COMMON_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off < WIN_LO) |-> (rd_bank == '0)); // R1
    AST_COMMON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off < WIN_LO) |-> (wr_bank == '0)); // R1
    AST_BSR_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (bsr_we && !ptr_ld[0] && !use0) |=> ($stable(p0_off) && $stable(p0_bank))); // R5
    AST_INC_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && use0 && !ptr_ld[0] && step0 == 2'b01 && p0_off == 8'hFF)
        |=> (p0_off == WIN_LO && p0_bank == $past(p0_bank) + BANK_ONE)); // R6
    AST_DEC_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && use0 && !ptr_ld[0] && step0 == 2'b10 && p0_off == WIN_LO)
        |=> (p0_off == 8'hFF && p0_bank == $past(p0_bank) - BANK_ONE)); // R7
    AST_PRE_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && acc_en && rd_sel == 2'b01 && !ptr_ld[0] && step0 == 2'b01 && rd_off != 8'hFF)
        |=> (p0_off == $past(rd_off) + 8'd1)); // R8
    AST_COMPAT_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext && use0 && !ptr_ld[0]) |=> $stable(p0_bank)); // R11
endmodule

bind bank_addr_unit bank_addr_checker #(.BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext     (ext_on),
    .acc_en  (acc_en),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel),
    .bsr_we  (bsr_we),
    .ptr_ld  (ptr_ld),
    .ld_step (ptr_ld_step),
    .p0_off  (ptr_off[0]),
    .p0_bank (ptr_bank[0]),
    .rd_bank (rd_bank),
    .rd_off  (rd_off),
    .wr_bank (wr_bank),
    .wr_off  (wr_off)
);

// File: tb/test_bank_addr_unit.sv
module test_bank_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acc_en;
    logic [1:0]        rd_sel, wr_sel;
    logic [7:0]        rd_dir_addr, wr_dir_addr;
    logic              bsr_we;
    logic [7:0]        bsr_wdata;
    logic              mode_we, mode_ext;
    logic [1:0]        ptr_ld;
    logic [7:0]        ptr_ld_off;
    logic [BANK_W-1:0] ptr_ld_bank;
    logic [1:0]        ptr_ld_step;
    logic [BANK_W-1:0] rd_bank, wr_bank;
    logic [7:0]        rd_off, wr_off;

    logic [7:0] ram [0:4095];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_addr_unit #(.BANK_W(BANK_W), .WIN_BASE(32)) i_bank_addr_unit (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en),
        .rd_sel(rd_sel), .rd_dir_addr(rd_dir_addr),
        .wr_sel(wr_sel), .wr_dir_addr(wr_dir_addr),
        .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
        .mode_we(mode_we), .mode_ext(mode_ext),
        .ptr_ld(ptr_ld), .ptr_ld_off(ptr_ld_off),
        .ptr_ld_bank(ptr_ld_bank), .ptr_ld_step(ptr_ld_step),
        .rd_bank(rd_bank), .rd_off(rd_off),
        .wr_bank(wr_bank), .wr_off(wr_off)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        acc_en = 0; rd_sel = 0; wr_sel = 0; rd_dir_addr = 0; wr_dir_addr = 0;
        bsr_we = 0; bsr_wdata = 0; mode_we = 0; mode_ext = 0;
        ptr_ld = 0; ptr_ld_off = 0; ptr_ld_bank = 0; ptr_ld_step = 0;
    endtask

    task automatic peek(logic [1:0] sel, logic [7:0] dir, output logic [15:0] v);
        @(negedge clk); clear_in();
        rd_sel = sel; rd_dir_addr = dir;
        #1 v = {rd_bank, rd_off};
    endtask

    task automatic write_bsr(logic [7:0] d);
        @(negedge clk); clear_in(); bsr_we = 1; bsr_wdata = d;
    endtask

    task automatic set_mode(logic e);
        @(negedge clk); clear_in(); mode_we = 1; mode_ext = e;
    endtask

    task automatic load_ptr(int idx, logic [7:0] o, logic [7:0] b, logic [1:0] s);
        @(negedge clk); clear_in();
        ptr_ld[idx] = 1'b1; ptr_ld_off = o; ptr_ld_bank = b; ptr_ld_step = s;
    endtask

    task automatic access(logic [1:0] rs, logic [1:0] ws,
                          output logic [15:0] rv, output logic [15:0] wv);
        @(negedge clk); clear_in();
        acc_en = 1; rd_sel = rs; wr_sel = ws;
        #1 rv = {rd_bank, rd_off}; wv = {wr_bank, wr_off};
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(2'b00, 8'h50, v); chk("R10 direct after reset", v, 16'h0050);
        peek(2'b01, 8'h00, v); chk("R10 ptr0 after reset", v, 16'h0000);
        peek(2'b10, 8'h00, v); chk("R10 ptr1 after reset", v, 16'h0000);
    endtask

    task automatic t_direct();
        logic [15:0] v;
        write_bsr(8'h50);
        peek(2'b00, 8'h80, v); chk("R2 direct bank nibble", v, 16'h0580);
        peek(2'b00, 8'h10, v); chk("R1 direct common", v, 16'h0010);
        peek(2'b11, 8'h90, v); chk("R2 select 11 direct", v, 16'h0590);
    endtask

    task automatic t_compat_bank();
        logic [15:0] v;
        load_ptr(0, 8'h40, 8'h13, 2'b00);
        peek(2'b01, 8'h00, v); chk("R4 compat uses bsr bank", v, 16'h0540);
    endtask

    task automatic t_ext_bank();
        logic [15:0] v;
        set_mode(1'b1);
        peek(2'b01, 8'h00, v); chk("R3 ext pointer bank", v, 16'h1340);
        write_bsr(8'h70);
        peek(2'b01, 8'h00, v); chk("R5 bsr write keeps pointer", v, 16'h1340);
        peek(2'b00, 8'h80, v); chk("R2 new direct bank", v, 16'h0780);
        load_ptr(0, 8'h05, 8'h09, 2'b00);
        peek(2'b01, 8'h00, v); chk("R1 ext common ignores bank", v, 16'h0005);
    endtask

    task automatic t_inc_wrap();
        logic [15:0] r, w, v;
        load_ptr(1, 8'hFE, 8'h02, 2'b01);
        access(2'b00, 2'b10, r, w); chk("R8 pre-step address", w, 16'h02FE);
        peek(2'b10, 8'h00, v); chk("R8 stepped after edge", v, 16'h02FF);
        access(2'b00, 2'b10, r, w);
        peek(2'b10, 8'h00, v); chk("R6 inc crosses bank", v, 16'h0320);
    endtask

    task automatic t_dec_wrap();
        logic [15:0] r, w, v;
        load_ptr(0, 8'h21, 8'h04, 2'b10);
        access(2'b01, 2'b00, r, w); chk("R8 dec pre-step", r, 16'h0421);
        peek(2'b01, 8'h00, v); chk("R7 dec inside window", v, 16'h0420);
        access(2'b01, 2'b00, r, w);
        peek(2'b01, 8'h00, v); chk("R7 dec crosses bank", v, 16'h03FF);
    endtask

    task automatic t_hold();
        logic [15:0] r, w, v;
        load_ptr(1, 8'h60, 8'h08, 2'b00);
        access(2'b10, 2'b10, r, w);
        access(2'b10, 2'b00, r, w);
        peek(2'b10, 8'h00, v); chk("R8 step 00 holds", v, 16'h0860);
        load_ptr(1, 8'h60, 8'h08, 2'b11);
        access(2'b00, 2'b10, r, w);
        peek(2'b10, 8'h00, v); chk("R8 step 11 holds", v, 16'h0860);
    endtask

    task automatic t_compat_step();
        logic [15:0] r, w, v;
        set_mode(1'b0);
        write_bsr(8'h30);
        load_ptr(0, 8'hFF, 8'h02, 2'b01);
        peek(2'b01, 8'h00, v); chk("R4 compat bank from bsr", v, 16'h03FF);
        access(2'b01, 2'b00, r, w);
        peek(2'b01, 8'h00, v); chk("R11 compat wraps to 00", v, 16'h0000);
        load_ptr(1, 8'h7F, 8'h06, 2'b01);
        access(2'b10, 2'b00, r, w);
        set_mode(1'b1);
        peek(2'b10, 8'h00, v); chk("R11 compat keeps ptr bank", v, 16'h0680);
    endtask

    task automatic t_move();
        logic [15:0] r, w, v;
        load_ptr(0, 8'h30, 8'h01, 2'b01);
        load_ptr(1, 8'hFF, 8'h05, 2'b01);
        ram[{4'h1, 8'h30}] = 8'hA5;
        ram[{4'h5, 8'hFF}] = 8'h00;
        access(2'b01, 2'b10, r, w);
        ram[{w[11:8], w[7:0]}] = ram[{r[11:8], r[7:0]}];
        chk("R9 read side", r, 16'h0130);
        chk("R9 write side", w, 16'h05FF);
        chk("R9 byte moved", {8'h00, ram[{4'h5, 8'hFF}]}, 16'h00A5);
        peek(2'b01, 8'h00, v); chk("R9 ptr0 stepped", v, 16'h0131);
        peek(2'b10, 8'h00, v); chk("R9 ptr1 stepped", v, 16'h0620);
    endtask

    task automatic t_load_wins();
        logic [15:0] v;
        load_ptr(0, 8'h40, 8'h02, 2'b01);
        @(negedge clk); clear_in();
        acc_en = 1; rd_sel = 2'b01;
        ptr_ld = 2'b01; ptr_ld_off = 8'h50; ptr_ld_bank = 8'h07; ptr_ld_step = 2'b01;
        peek(2'b01, 8'h00, v); chk("R12 load beats step", v, 16'h0750);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_compat_bank();
        t_ext_bank();
        t_inc_wrap();
        t_dec_wrap();
        t_hold();
        t_compat_step();
        t_move();
        t_load_wins();
        @(negedge clk); clear_in();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule